// File: doc/BRIEF.md
# Bidirectional Port with Per-Pin Direction Control

This block is one general-purpose I/O port of a small microcontroller. It holds two software-visible registers: an output latch and a direction register, where each direction bit configures one pin. Both registers are written and read over a plain register bus. The bus has an address, separate write and read enables, and write and read data. On the pad side the block produces an output value and an output enable for every pin. It also takes the pad level back in through a two-stage synchronizer.

A read of the data register is mixed per pin. For a pin set as an output it returns the latched bit, and for a pin set as an input it returns the synchronized pad level. A write to an input pin is not lost: it lands in the latch, and it appears on the pad as soon as the pin is turned to an output. A build parameter chooses the output stage. The push-pull stage drives both levels. The open-drain stage can only pull low and releases the pin for a latched 1. A per-pin alternate-function select lets a peripheral's data and enable take over the pad. The latch and direction registers keep working underneath.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and afterwards until the first write, the direction register and output latch are all zeros, so every pin with its alternate select low has output enable 0 and reads of either register return 0.
- R2: Direction bit value 1 makes that pin an output and 0 makes it an input, each bit affecting only its own pin. With push-pull stage and alternate select low, padOe equals the direction register from the cycle after the write.
- R3: A pin whose direction bit is 0 and whose alternate select is low has output enable 0 in both output stages.
- R4: A read at address 0 returns, for every pin whose direction bit is 1, the output latch bit and not the pad level.
- R5: A read at address 0 returns, for every pin whose direction bit is 0, the pad level delayed by two flops. A pad change made before a clock edge is still invisible after that edge and is visible after the second edge.
- R6: A write at address 0 updates the latch bit of input pins without driving them. When such a pin is later switched to output, it drives the stored latch value in the cycle right after the direction write.
- R7: Address 1 holds the direction register, and a read there returns exactly the value last written. Address 0 is the data register.
- R8: With the open-drain stage (OPEN_DRAIN=1), padOut is always 0. An output pin with latch 1 has output enable 0, and one with latch 0 has output enable 1.
- R9: A pin whose altSel bit is 1 takes its data from altOut and its enable from altOe in place of latch and direction bit; the open-drain rule of R8 still applies. Writes to the latch during that time are stored and read back after altSel returns to 0.
- R10: busRdata is 0 whenever busRe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register select: 0 data, 1 direction |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | WIDTH | Write data |
| busRdata | output | WIDTH | Read data, combinational, 0 when not reading |
| padIn | input | WIDTH | Level seen at the pads |
| altSel | input | WIDTH | Per-pin alternate-function select |
| altOut | input | WIDTH | Alternate-function output data |
| altOe | input | WIDTH | Alternate-function output enable |
| padOut | output | WIDTH | Pad output value |
| padOe | output | WIDTH | Pad output enable, 1 drives the pad |

## Verification
The bench builds two copies with WIDTH=4: one with the push-pull stage and one with OPEN_DRAIN=1. Both are fed the same bus and pad stimulus. At four pins, every combination of direction, latch and pad level (4096 cases) is small enough to sweep completely. Every combination of altSel, altOut and altOe can also be swept over fixed latch and direction values, so the per-pin read mix and both output stages are covered for all cases. The synchronizer latency and the input-to-output switch are also checked cycle by cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets on the bus
  localparam int DATA_OFS = 0;
  localparam int DIR_OFS  = 1;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output portStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DirAddr  = ADDR_W'(DIR_OFS);

  logic hitData;
  logic hitDir;

  always_comb begin
    hitData       = (busAddr == DataAddr);
    hitDir        = (busAddr == DirAddr);
    strobe.wrData = busWe & hitData;
    strobe.wrDir  = busWe & hitDir;
    strobe.rdData = busRe & hitData;
    strobe.rdDir  = busRe & hitDir;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit OPEN_DRAIN  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] altSel,
  input  logic [WIDTH-1:0] altOut,
  input  logic [WIDTH-1:0] altOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);

  localparam int LastStage = SYNC_STAGES - 1;

  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] padSync;
  logic [WIDTH-1:0] portView;
  logic [WIDTH-1:0] effOut;
  logic [WIDTH-1:0] effOe;

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      if (strobe.wrData) latchQ <= wdata;
      if (strobe.wrDir)  dirQ   <= wdata;
    end
  end

  // Pad input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign padSync = syncQ[LastStage];

  // Per-pin read mix: latch for outputs, pad for inputs
  assign portView = (dirQ & latchQ) | (~dirQ & padSync);

  always_comb begin
    if (strobe.rdData)     rdata = portView;
    else if (strobe.rdDir) rdata = dirQ;
    else                   rdata = '0;
  end

  // Alternate-function override per pin
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign effOut[i] = altSel[i] ? altOut[i] : latchQ[i];
    assign effOe[i]  = altSel[i] ? altOe[i]  : dirQ[i];
  end

  // Output stage variant
  if (OPEN_DRAIN) begin : g_od
    assign padOut = '0;
    assign padOe  = effOe & ~effOut;
  end else begin : g_pp
    assign padOut = effOut;
    assign padOe  = effOe;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 1,
  parameter bit OPEN_DRAIN  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  altSel,
  input  logic [WIDTH-1:0]  altOut,
  input  logic [WIDTH-1:0]  altOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);

  portStrobe_t strobe;

  gpio_port_ctrl #(
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .busRe  (busRe),
    .strobe (strobe)
  );

  gpio_port_dp #(
    .WIDTH      (WIDTH),
    .OPEN_DRAIN (OPEN_DRAIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (busWdata),
    .rdata (busRdata),
    .padIn (padIn),
    .altSel(altSel),
    .altOut(altOut),
    .altOe (altOe),
    .padOut(padOut),
    .padOe (padOe)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH      = 8,
  parameter int ADDR_W     = 1,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  altSel,
  input logic [WIDTH-1:0]  altOe,
  input logic [WIDTH-1:0]  padOe
);

  localparam logic [ADDR_W-1:0] DataAddr = ADDR_W'(gpio_port_pkg::DATA_OFS);
  localparam logic [ADDR_W-1:0] DirAddr  = ADDR_W'(gpio_port_pkg::DIR_OFS);

  // R1: pins held in reset are not driven unless a peripheral owns them
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_float_R1: assert ((padOe & ~altSel) == '0)
        else $error("R1 pad driven during reset");
    end
  end

  // R2: push-pull enable follows a new direction value
  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DirAddr)
      |=> (OPEN_DRAIN || altSel != '0 || padOe == $past(busWdata)));

  // R3: pins written as inputs stay undriven
  assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DirAddr)
      |=> ((padOe & ~$past(busWdata) & ~altSel) == '0));

  // R7: direction register reads back the written value
  assert_dir_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DirAddr)
      |=> (!busRe || busAddr != DirAddr || busRdata == $past(busWdata)));

  // R8: open-drain releases pins whose latch holds 1
  assert_od_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DataAddr)
      |=> (!OPEN_DRAIN || (padOe & $past(busWdata) & ~altSel) == '0));

  // R9: with push-pull stage an owned pin takes the peripheral enable
  assert_alt_oe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !OPEN_DRAIN |-> ((padOe & altSel) == (altOe & altSel)));

  // R10: idle bus returns zero
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == '0);

endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH     (WIDTH),
  .ADDR_W    (ADDR_W),
  .OPEN_DRAIN(OPEN_DRAIN)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busRe   (busRe),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .altSel  (altSel),
  .altOe   (altOe),
  .padOe   (padOe)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/100ps
module gpio_port_tb_top;

  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [0:0]   busAddr = '0;
  logic         busWe = 1'b0;
  logic         busRe = 1'b0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] altSel = '0;
  logic [W-1:0] altOut = '0;
  logic [W-1:0] altOe = '0;
  logic [W-1:0] rdPp, rdOd, outPp, outOd, oePp, oeOd;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(1), .OPEN_DRAIN(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(rdPp), .padIn(padIn), .altSel(altSel),
    .altOut(altOut), .altOe(altOe), .padOut(outPp), .padOe(oePp)
  );

  gpio_port #(.WIDTH(W), .ADDR_W(1), .OPEN_DRAIN(1'b1)) dut_od_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(rdOd), .padIn(padIn), .altSel(altSel),
    .altOut(altOut), .altOe(altOe), .padOut(outOd), .padOe(oeOd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    busAddr  = 1'(addr);
    busWdata = W'(data);
    busWe    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // Combinational read away from the clock edge
  task automatic readReg(input int addr, output int valPp, output int valOd);
    busAddr = 1'(addr);
    busRe   = 1'b1;
    #1;
    valPp = int'(rdPp);
    valOd = int'(rdOd);
    busRe = 1'b0;
    #0.5;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rp, ro;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 oe pp", int'(oePp), 0);
    check("R1 oe od", int'(oeOd), 0);
    rstN = 1'b1;
    tick();
    readReg(1, rp, ro);
    check("R1 dir", rp, 0);
    readReg(0, rp, ro);
    check("R1 data", rp, 0);
    check("R1 oe after reset", int'(oePp), 0);

    // R10: idle bus reads zero
    writeReg(1, M);
    writeReg(0, 'h9);
    #1;
    check("R10 idle rdata pp", int'(rdPp), 0);
    check("R10 idle rdata od", int'(rdOd), 0);

    // R5: synchronizer latency
    writeReg(1, 0);
    padIn = '0;
    tick(); tick();
    padIn = W'(M);
    tick();
    readReg(0, rp, ro);
    check("R5 one edge still old", rp, 0);
    tick();
    readReg(0, rp, ro);
    check("R5 two edges new", rp, M);

    // R6: write while input, then switch to output
    padIn = '0;
    writeReg(0, 'hA);
    check("R6 undriven after latch write", int'(oePp), 0);
    writeReg(1, M);
    check("R6 drives stored latch out", int'(outPp), 'hA);
    check("R6 drives stored latch oe", int'(oePp), M);

    // R2 R3 R4 R5 R7 R8: full sweep of direction, latch and pad
    for (int d = 0; d <= M; d++) begin
      for (int l = 0; l <= M; l++) begin
        writeReg(0, l);
        writeReg(1, d);
        for (int p = 0; p <= M; p++) begin
          int expRd;
          padIn = W'(p);
          tick(); tick();
          expRd = ((d & l) | (~d & p)) & M;
          readReg(0, rp, ro);
          check("R4 R5 data read pp", rp, expRd);
          check("R4 R5 data read od", ro, expRd);
          if (p == 0) begin
            readReg(1, rp, ro);
            check("R7 dir readback", rp, d);
            check("R2 R3 oe pp", int'(oePp), d);
            check("R6 out pp", int'(outPp), l);
            check("R8 oe od", int'(oeOd), d & ~l & M);
            check("R8 out od", int'(outOd), 0);
          end
        end
      end
    end

    // R9: alternate function sweep
    writeReg(0, 'h3);
    writeReg(1, 'h5);
    for (int s = 0; s <= M; s++) begin
      for (int a = 0; a <= M; a++) begin
        for (int e = 0; e <= M; e++) begin
          int eo, ee;
          altSel = W'(s);
          altOut = W'(a);
          altOe  = W'(e);
          #1;
          eo = ((s & a) | (~s & 'h3)) & M;
          ee = ((s & e) | (~s & 'h5)) & M;
          check("R9 alt out pp", int'(outPp), eo);
          check("R9 alt oe pp", int'(oePp), ee);
          check("R9 alt oe od", int'(oeOd), ee & ~eo & M);
        end
      end
    end
    @(negedge clk);
    altSel = W'(M);
    altOut = '0;
    altOe  = '0;
    writeReg(0, 'hC);
    check("R9 owned pins not driven by latch", int'(oePp), 0);
    altSel = '0;
    writeReg(1, M);
    readReg(0, rp, ro);
    check("R9 latch stored under alt", rp, 'hC);
    check("R9 latch on pad after release", int'(outPp), 'hC);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule